// File: doc/BRIEF.md
# Stack Pointer Delta Tracker

This block sits in the decode front end and keeps the speculative part of the stack pointer. The pointer that software sees is split in two: a base value held by the execution core and a signed byte offset held here. Push, pop, call and return change only the offset. They are accumulated by a small local adder and never cost a separate add or subtract micro-op in the core. Every accepted instruction receives the offset to fold into its stack-relative address as a displacement.

When an instruction names the stack register as an ordinary operand, the core needs the real pointer. The tracker then asks for a synchronisation micro-op, placed ahead of that instruction, which adds the current offset to the core's base value. The offset is then cleared. The same request is raised early when the next update would overflow the offset register. Each instruction's offset before and after it executes is written into a checkpoint table indexed by its sequence tag. On a flush, either value can be reloaded.

Top module: `spd_tracker`

## Requirements
- R1: Kind code 1 (push) lowers the offset by the operand size, which is 2 << size code (size code 0..3 gives 2, 4, 8 or 16 bytes). Kind code 3 (call) lowers it by a fixed 4 bytes. For both, the reported displacement equals the lowered offset.
- R2: Kind code 2 (pop) raises the offset by the operand size. Kind code 4 (return) raises it by 4 bytes. For both, the reported displacement equals the offset before the increase.
- R3: Kind code 0 and the unused codes 5..7 leave the offset unchanged and report it as the displacement. Consecutive instructions chain with no sync request: each one's pre-offset equals the previous one's post-offset.
- R4: When an instruction marks explicit stack-register use and the offset is non-zero, a sync request is raised with a sync amount equal to that offset. The instruction then sees a pre-offset of zero.
- R5: A sync request is never raised while the offset is zero.
- R6: When a push, call, pop or return would take the signed offset outside its DW-bit range, a sync request carrying the old offset is raised first. The update is then applied starting from zero.
- R7: Every accepted instruction reports its pre-offset and post-offset, and the tracker stores both under that instruction's tag.
- R8: A recovery request with a tag and a before/after select reloads the offset from that tag's stored pre-offset (select 0) or post-offset (select 1). Instructions presented in the recovery cycle and in the cycle after it are dropped. Tracking resumes from the reloaded offset in the second cycle after the request.
- R9: Results appear one clock after the instruction is presented. A cycle with no accepted instruction gives no valid result and leaves the offset unchanged.
- R10: After reset the offset is zero and the valid and sync outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_kind | input | 3 | Stack operation kind code |
| in_size | input | 2 | Operand size code for push and pop |
| in_uses_sp | input | 1 | Instruction uses the stack register as an ordinary operand |
| in_tag | input | TAG_W | Sequence tag of the instruction |
| rec_valid | input | 1 | Recovery request |
| rec_tag | input | TAG_W | Tag to recover to |
| rec_after | input | 1 | 0 reloads the pre-offset, 1 reloads the post-offset |
| res_valid | output | 1 | Result for an accepted instruction |
| res_tag | output | TAG_W | Tag of that instruction |
| res_disp | output | DW | Displacement for stack-relative addressing |
| sync_req | output | 1 | Insert a sync micro-op ahead of the instruction |
| sync_add | output | DW | Amount the sync micro-op adds to the base value |
| ckpt_pre | output | DW | Offset before the instruction |
| ckpt_post | output | DW | Offset after the instruction |

## Verification
Every per-instruction result is due exactly one clock after the instruction is presented. The bench drives on a falling edge and reads the outputs on the next falling edge, half a period after the edge that registered them. A recovery takes two clocks: the request cycle and the table-read cycle. The bench presents a push in both cycles, checks that neither produces a result, and then sends an instruction whose pre-offset exposes the reloaded value. Overflow cases use an 8-bit offset, so the early sync is reached within a few 16-byte pushes or pops.

// File: rtl/spd_pkg.sv
package spd_pkg;

  // Stack operation kind codes carried on in_kind.
  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_PUSH = 3'd1,
    K_POP  = 3'd2,
    K_CALL = 3'd3,
    K_RET  = 3'd4
  } stk_kind_e;

  // Width of the byte-count path (largest size is 16 bytes).
  localparam int NB_W = 5;

endpackage

// File: rtl/spd_step.sv
// Combinational next-offset calculation for one instruction.
module spd_step
  import spd_pkg::*;
#(
  parameter int DW         = 16,
  parameter int CALL_BYTES = 4
) (
  input  logic [DW-1:0] delta_i,
  input  logic [2:0]    kind_i,
  input  logic [1:0]    size_i,
  input  logic          uses_i,
  output logic          sync_o,
  output logic [DW-1:0] pre_o,
  output logic [DW-1:0] post_o,
  output logic [DW-1:0] disp_o
);

  localparam int SW = DW + 1;

  logic            dec, inc, ovf;
  logic [NB_W-1:0] nbytes;
  logic [SW-1:0]   ext, sz, trial;
  logic [DW-1:0]   base, szn;

  always_comb begin
    dec    = (kind_i == K_PUSH) || (kind_i == K_CALL);
    inc    = (kind_i == K_POP)  || (kind_i == K_RET);
    nbytes = ((kind_i == K_CALL) || (kind_i == K_RET)) ? NB_W'(CALL_BYTES)
                                                        : (NB_W'(2) << size_i);
    // Trial update one bit wider to spot leaving the signed range.
    ext    = {delta_i[DW-1], delta_i};
    sz     = SW'(nbytes);
    trial  = dec ? (ext - sz) : (ext + sz);
    ovf    = (dec || inc) && (trial[SW-1] != trial[SW-2]);
    sync_o = (uses_i || ovf) && (delta_i != '0);
    base   = sync_o ? '0 : delta_i;
    szn    = DW'(nbytes);
    if (dec)      post_o = base - szn;
    else if (inc) post_o = base + szn;
    else          post_o = base;
    pre_o  = base;
    disp_o = dec ? post_o : base;
  end

endmodule

// File: rtl/spd_ckpt_ram.sv
// Simple dual-port table: one write port, one registered read port.
module spd_ckpt_ram #(
  parameter int AW = 6,
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [WW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/spd_tracker.sv
module spd_tracker #(
  parameter int DW         = 16,
  parameter int TAG_W      = 6,
  parameter int CALL_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       in_kind,
  input  logic [1:0]       in_size,
  input  logic             in_uses_sp,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             rec_valid,
  input  logic [TAG_W-1:0] rec_tag,
  input  logic             rec_after,
  output logic             res_valid,
  output logic [TAG_W-1:0] res_tag,
  output logic [DW-1:0]    res_disp,
  output logic             sync_req,
  output logic [DW-1:0]    sync_add,
  output logic [DW-1:0]    ckpt_pre,
  output logic [DW-1:0]    ckpt_post
);

  localparam int EW = 2 * DW;

  logic [DW-1:0] delta_q;
  logic          restore_q;
  logic          after_q;
  logic          accept;

  logic          st_sync;
  logic [DW-1:0] st_pre, st_post, st_disp;
  logic [EW-1:0] rd_entry;

  assign accept = in_valid && !rec_valid && !restore_q;

  spd_step #(
    .DW        (DW),
    .CALL_BYTES(CALL_BYTES)
  ) step_i (
    .delta_i(delta_q),
    .kind_i (in_kind),
    .size_i (in_size),
    .uses_i (in_uses_sp),
    .sync_o (st_sync),
    .pre_o  (st_pre),
    .post_o (st_post),
    .disp_o (st_disp)
  );

  spd_ckpt_ram #(
    .AW(TAG_W),
    .WW(EW)
  ) ckpt_i (
    .clk    (clk),
    .wr_en  (accept),
    .wr_addr(in_tag),
    .wr_data({st_pre, st_post}),
    .rd_en  (rec_valid),
    .rd_addr(rec_tag),
    .rd_data(rd_entry)
  );

  // Offset register and recovery sequencing.
  always_ff @(posedge clk) begin
    if (rst) begin
      delta_q   <= '0;
      restore_q <= 1'b0;
      after_q   <= 1'b0;
    end else begin
      restore_q <= rec_valid;
      if (rec_valid) after_q <= rec_after;
      if (restore_q)   delta_q <= after_q ? rd_entry[DW-1:0] : rd_entry[EW-1:DW];
      else if (accept) delta_q <= st_post;
    end
  end

  // Registered per-instruction results.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_tag   <= '0;
      res_disp  <= '0;
      sync_req  <= 1'b0;
      sync_add  <= '0;
      ckpt_pre  <= '0;
      ckpt_post <= '0;
    end else begin
      res_valid <= accept;
      sync_req  <= accept && st_sync;
      if (accept) begin
        res_tag   <= in_tag;
        res_disp  <= st_disp;
        sync_add  <= st_sync ? delta_q : '0;
        ckpt_pre  <= st_pre;
        ckpt_post <= st_post;
      end
    end
  end

endmodule

// File: rtl/spd_tracker_chk.sv
module spd_tracker_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    in_kind,
  input logic          in_uses_sp,
  input logic          rec_valid,
  input logic          res_valid,
  input logic [DW-1:0] res_disp,
  input logic          sync_req,
  input logic [DW-1:0] sync_add,
  input logic [DW-1:0] ckpt_pre,
  input logic [DW-1:0] ckpt_post,
  input logic [DW-1:0] delta_q
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r5_no_sync_on_zero: assert property (@(posedge clk) disable iff (rst)
    sync_req |-> (sync_add != '0));

  a_r4_sync_carries_offset: assert property (@(posedge clk) disable iff (rst)
    (past_ok && sync_req) |-> (sync_add == $past(delta_q)));

  a_r4_use_sees_zero: assert property (@(posedge clk) disable iff (rst)
    (past_ok && res_valid && $past(in_uses_sp)) |-> (ckpt_pre == '0));

  a_r3_chain: assert property (@(posedge clk) disable iff (rst)
    (past_ok && res_valid && !sync_req) |-> (ckpt_pre == $past(delta_q)));

  a_r1_push_disp: assert property (@(posedge clk) disable iff (rst)
    (past_ok && res_valid && ($past(in_kind) == 3'd1 || $past(in_kind) == 3'd3))
      |-> (res_disp == ckpt_post && $signed(ckpt_post) < $signed(ckpt_pre)));

  a_r2_pop_disp: assert property (@(posedge clk) disable iff (rst)
    (past_ok && res_valid && ($past(in_kind) == 3'd2 || $past(in_kind) == 3'd4))
      |-> (res_disp == ckpt_pre && $signed(ckpt_post) > $signed(ckpt_pre)));

  a_r8_drop_on_recovery: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rec_valid)) |-> !res_valid);

endmodule

bind spd_tracker spd_tracker_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_kind   (in_kind),
  .in_uses_sp(in_uses_sp),
  .rec_valid (rec_valid),
  .res_valid (res_valid),
  .res_disp  (res_disp),
  .sync_req  (sync_req),
  .sync_add  (sync_add),
  .ckpt_pre  (ckpt_pre),
  .ckpt_post (ckpt_post),
  .delta_q   (delta_q)
);

// File: tb/spd_tracker_tb_top.sv
module spd_tracker_tb_top;

  localparam int DW    = 8;
  localparam int TAG_W = 4;
  localparam int NTAG  = 1 << TAG_W;
  localparam int DMAX  = (1 << (DW - 1)) - 1;
  localparam int DMIN  = -(1 << (DW - 1));

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [2:0]       in_kind = '0;
  logic [1:0]       in_size = '0;
  logic             in_uses_sp = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             rec_valid = 1'b0;
  logic [TAG_W-1:0] rec_tag = '0;
  logic             rec_after = 1'b0;
  logic             res_valid;
  logic [TAG_W-1:0] res_tag;
  logic [DW-1:0]    res_disp;
  logic             sync_req;
  logic [DW-1:0]    sync_add;
  logic [DW-1:0]    ckpt_pre;
  logic [DW-1:0]    ckpt_post;

  always #2.5 clk = ~clk;

  spd_tracker #(.DW(DW), .TAG_W(TAG_W), .CALL_BYTES(4)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_size(in_size), .in_uses_sp(in_uses_sp), .in_tag(in_tag),
    .rec_valid(rec_valid), .rec_tag(rec_tag), .rec_after(rec_after),
    .res_valid(res_valid), .res_tag(res_tag), .res_disp(res_disp),
    .sync_req(sync_req), .sync_add(sync_add), .ckpt_pre(ckpt_pre),
    .ckpt_post(ckpt_post)
  );

  int checks = 0;
  int errors = 0;
  int md = 0;
  int tag_ctr = 0;
  int mpre [NTAG];
  int mpost [NTAG];
  int g_pre = 0;
  bit done = 0;

  function automatic int sx(input logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Present one instruction, compute the expected result from the
  // requirements, and check it one clock later.
  task automatic send(input int kind, input int code, input int uses);
    int  sz, pre, post, disp, add;
    bit  dec, inc, ovf, sy;
    string kreq;
    @(negedge clk);
    in_valid = 1'b1; in_kind = 3'(kind); in_size = 2'(code);
    in_uses_sp = 1'(uses); in_tag = TAG_W'(tag_ctr);
    dec = (kind == 1 || kind == 3);
    inc = (kind == 2 || kind == 4);
    sz  = (kind == 3 || kind == 4) ? 4 : (2 << code);
    ovf = (dec && (md - sz < DMIN)) || (inc && (md + sz > DMAX));
    sy  = (uses != 0 || ovf) && (md != 0);
    add = md;
    pre = sy ? 0 : md;
    post = dec ? pre - sz : inc ? pre + sz : pre;
    disp = dec ? post : pre;
    kreq = dec ? "R1" : inc ? "R2" : "R3";
    mpre[tag_ctr] = pre; mpost[tag_ctr] = post;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 res_valid", int'(res_valid), 1);
    chk("R7 res_tag", int'(res_tag), tag_ctr);
    chk({kreq, " displacement"}, sx(res_disp), disp);
    chk(sy ? "R3 pre-offset after sync" : "R3 chained pre-offset", sx(ckpt_pre), pre);
    chk({kreq, " post-offset R7"}, sx(ckpt_post), post);
    if (ovf && md != 0)      chk("R6 early sync", int'(sync_req), 1);
    else if (uses != 0 && md != 0) chk("R4 sync request", int'(sync_req), 1);
    else if (md == 0)        chk("R5 no sync at zero", int'(sync_req), 0);
    else                     chk("R3 no sync", int'(sync_req), 0);
    if (sy) chk("R4 sync amount", sx(sync_add), add);
    g_pre = sx(ckpt_pre);
    md = post;
    tag_ctr = (tag_ctr + 1) % NTAG;
  endtask

  task automatic recover(input int tag, input int after);
    int exp;
    @(negedge clk);
    rec_valid = 1'b1; rec_tag = TAG_W'(tag); rec_after = 1'(after);
    in_valid = 1'b1; in_kind = 3'd1; in_size = 2'd3; in_uses_sp = 1'b0;
    @(negedge clk);
    rec_valid = 1'b0;
    chk("R8 dropped in recovery cycle", int'(res_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 dropped in restore cycle", int'(res_valid), 0);
    exp = (after != 0) ? mpost[tag] : mpre[tag];
    md = exp;
    tag_ctr = (tag + 1) % NTAG;
    send(0, 0, 0);
    chk("R8 reloaded offset", g_pre, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 res_valid after reset", int'(res_valid), 0);
    chk("R10 sync_req after reset", int'(sync_req), 0);
    send(0, 0, 0);
    chk("R10 offset zero after reset", g_pre, 0);

    // Sweep kinds, size codes and explicit-use flag, twice.
    for (int rep = 0; rep < 2; rep++)
      for (int k = 0; k < 6; k++)
        for (int c = 0; c < 4; c++)
          for (int u = 0; u < 2; u++)
            send(k, c, u);

    // Idle cycles: no result, offset held (R9).
    send(1, 1, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R9 idle gives no result", int'(res_valid), 0);
    end
    begin
      int held;
      held = md;
      send(0, 0, 0);
      chk("R9 offset held over idle", g_pre, held);
    end

    // Clear the offset, then run into both range limits (R6).
    send(0, 0, 1);
    send(0, 0, 1);
    for (int i = 0; i < 12; i++) send(1, 3, 0);
    for (int i = 0; i < 20; i++) send(2, 3, 0);
    for (int i = 0; i < 40; i++) send(3, 0, 0);
    for (int i = 0; i < 40; i++) send(4, 0, 0);

    // Build a mixed history, then recover to pre- and post-offsets (R8).
    for (int i = 0; i < NTAG; i++) send(1 + (i % 4), i % 4, (i % 5 == 0) ? 1 : 0);
    for (int r = 0; r < 6; r++) begin
      recover((tag_ctr + NTAG - 2 - r) % NTAG, r % 2);
      send(1, r % 4, 0);
      send(2, (r + 1) % 4, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule